// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This controller sits beside the hazard logic of an in-order five-stage pipeline and turns faults into precise exceptions. Each cycle it looks at three kinds of event. The first is an arithmetic overflow raised by the instruction in the execute stage. The second is a bad opcode or a system-call request seen on the instruction in the decode stage. The third is an interrupt request from an external I/O controller. It picks the event that belongs to the oldest instruction. In that same cycle it tells the pipeline which inter-stage registers to load with bubbles. For an overflow it also removes the register write of the faulting instruction. Instructions further down the pipeline drain normally.

At the clock edge that ends the detection cycle, the controller saves two values: the address of the faulting instruction in the exception PC and a 5-bit code in the cause register. During the next cycle it raises a fetch redirect that carries the fixed handler address. In that redirect cycle it also kills the one wrong-path instruction fetched meanwhile, and it ignores every event input. The pipeline registers themselves, the handler software and the return path are outside the block.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The stage-valid inputs only tell the block which stage slots hold real instructions.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is held and right after it, `epc` and `cause` read 0, `redirect` is 0 and `handler_pc` is 0. With all event inputs low, every flush output and `wb_squash` are 0.
- R2: An overflow (`ex_ovf` with `ex_valid`) outside a redirect cycle drives `flush_ifid`, `flush_idex`, `flush_exmem` and `wb_squash` high in the same cycle, so the faulting result never reaches the register file.
- R3: A decode-stage fault (`id_illegal` or `id_syscall` with `id_valid`) that is not beaten by an overflow drives `flush_ifid` and `flush_idex` high and keeps `flush_exmem` and `wb_squash` low, so the older execute-stage instruction completes.
- R4: One cycle after an event is taken, `epc` holds the PC of the instruction it belongs to: `ex_pc` for an overflow and `id_pc` for any decode-stage event or an interrupt.
- R5: One cycle after an event is taken, `cause` holds its 5-bit code: 12 for overflow, 10 for invalid opcode, 8 for system call, 0 for interrupt.
- R6: When several events are present in one cycle, the winner is chosen in this order: overflow first, then invalid opcode, then system call, then interrupt.
- R7: In the cycle after a taken event, `redirect` is 1 for exactly one cycle, `handler_pc` is 0x80000180 and `flush_ifid` is 1. In every other cycle `redirect` and `handler_pc` are 0.
- R8: During a redirect cycle all event inputs are ignored. `flush_idex`, `flush_exmem` and `wb_squash` stay 0, and `epc` and `cause` keep their values into the next cycle.
- R9: An overflow without `ex_valid`, or a decode-stage fault or interrupt without `id_valid`, has no effect. No flush is raised, no redirect follows, and `epc` and `cause` are unchanged.
- R10: An interrupt request is taken only when `id_valid` is 1. It flushes the decode-stage instruction like a decode fault and records that instruction's PC.
- R11: Between events, `epc` and `cause` hold their last captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Overflow from the execute-stage ALU |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_illegal | input | 1 | Decoder found an invalid opcode |
| id_syscall | input | 1 | Decoder found a system-call instruction |
| id_pc | input | 32 | PC of the decode-stage instruction |
| irq | input | 1 | External interrupt request |
| flush_ifid | output | 1 | Load a bubble into the fetch/decode register |
| flush_idex | output | 1 | Load a bubble into the decode/execute register |
| flush_exmem | output | 1 | Load a bubble into the execute/memory register |
| wb_squash | output | 1 | Drop the register write of the execute-stage instruction |
| redirect | output | 1 | Fetch takes `handler_pc` as the next PC |
| handler_pc | output | 32 | Handler address while `redirect` is high, else 0 |
| epc | output | 32 | Saved PC of the last excepting instruction |
| cause | output | 5 | Code of the last exception |

## Verification
The controller is driven with each event source on its own, so that each code, each saved PC and the two flush footprints can be seen separately: the overflow clears three stages, while a decode-stage event clears two and lets the execute-stage instruction complete. Next come pairs and triples of sources in the same cycle, which show whether the priority order is correct. Events are also raised with their stage-valid low, and events are fired during the redirect cycle, which shows that gating and blocking hold. Finally, a long stretch of random event mixes, including back-to-back faults, is compared against a behavioural model on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 5;
  localparam int NSRC    = 4;   // index order is priority order, 0 wins

  typedef enum logic [CAUSE_W-1:0] {
    CODE_IRQ = 5'd0,
    CODE_SYS = 5'd8,
    CODE_ILL = 5'd10,
    CODE_OVF = 5'd12
  } exc_code_e;

  typedef struct packed {
    logic               take;
    logic               from_ex;
    logic [CAUSE_W-1:0] code;
  } exc_pick_t;

  function automatic logic [CAUSE_W-1:0] code_of(input int idx);
    case (idx)
      0:       return CODE_OVF;
      1:       return CODE_ILL;
      2:       return CODE_SYS;
      default: return CODE_IRQ;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         block,
  input  logic         ex_valid,
  input  logic         ex_ovf,
  input  logic [W-1:0] ex_pc,
  input  logic         id_valid,
  input  logic         id_illegal,
  input  logic         id_syscall,
  input  logic         irq,
  input  logic [W-1:0] id_pc,
  output exc_pick_t    pick,
  output logic [W-1:0] pick_pc
);
  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] in_ex;

  always_comb begin
    hit      = '0;
    in_ex    = '0;
    hit[0]   = ex_valid & ex_ovf;
    in_ex[0] = 1'b1;
    hit[1]   = id_valid & id_illegal;
    hit[2]   = id_valid & id_syscall;
    hit[3]   = id_valid & irq;
  end

  // walk from lowest to highest priority so the oldest source overwrites
  always_comb begin
    pick    = '0;
    pick_pc = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i] && !block) begin
        pick.take    = 1'b1;
        pick.from_ex = in_ex[i];
        pick.code    = code_of(i);
        pick_pc      = in_ex[i] ? ex_pc : id_pc;
      end
    end
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [W-1:0]  pc_in,
  input  logic [CW-1:0] code_in,
  output logic [W-1:0]  epc,
  output logic [CW-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else if (capture) begin
      epc   <= pc_in;
      cause <= code_in;
    end
  end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int         W      = XLEN,
  parameter logic [W-1:0] VECTOR = 32'h8000_0180
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         taken,
  output logic         redirect,
  output logic [W-1:0] handler_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect <= 1'b0;
    else        redirect <= taken;
  end

  assign handler_pc = redirect ? VECTOR : '0;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int             W      = XLEN,
  parameter logic [W-1:0]   VECTOR = 32'h8000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ex_valid,
  input  logic               ex_ovf,
  input  logic [W-1:0]       ex_pc,
  input  logic               id_valid,
  input  logic               id_illegal,
  input  logic               id_syscall,
  input  logic [W-1:0]       id_pc,
  input  logic               irq,
  output logic               flush_ifid,
  output logic               flush_idex,
  output logic               flush_exmem,
  output logic               wb_squash,
  output logic               redirect,
  output logic [W-1:0]       handler_pc,
  output logic [W-1:0]       epc,
  output logic [CAUSE_W-1:0] cause
);
  exc_pick_t    pick;
  logic [W-1:0] pick_pc;

  exc_arbiter #(.W(W)) u_arb (
    .block      (redirect),
    .ex_valid   (ex_valid),
    .ex_ovf     (ex_ovf),
    .ex_pc      (ex_pc),
    .id_valid   (id_valid),
    .id_illegal (id_illegal),
    .id_syscall (id_syscall),
    .irq        (irq),
    .id_pc      (id_pc),
    .pick       (pick),
    .pick_pc    (pick_pc)
  );

  exc_state_regs #(.W(W), .CW(CAUSE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (pick.take),
    .pc_in   (pick_pc),
    .code_in (pick.code),
    .epc     (epc),
    .cause   (cause)
  );

  exc_redirect #(.W(W), .VECTOR(VECTOR)) u_redir (
    .clk        (clk),
    .rst_n      (rst_n),
    .taken      (pick.take),
    .redirect   (redirect),
    .handler_pc (handler_pc)
  );

  // the redirect cycle also kills the one wrong-path fetch
  assign flush_ifid  = pick.take | redirect;
  assign flush_idex  = pick.take;
  assign flush_exmem = pick.take & pick.from_ex;
  assign wb_squash   = pick.take & pick.from_ex;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
  import exc_pkg::*;
#(
  parameter int           W      = XLEN,
  parameter logic [W-1:0] VECTOR = 32'h8000_0180
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ex_valid,
  input logic               ex_ovf,
  input logic [W-1:0]       ex_pc,
  input logic               id_valid,
  input logic               id_illegal,
  input logic               id_syscall,
  input logic [W-1:0]       id_pc,
  input logic               irq,
  input logic               flush_ifid,
  input logic               flush_idex,
  input logic               flush_exmem,
  input logic               wb_squash,
  input logic               redirect,
  input logic [W-1:0]       handler_pc,
  input logic [W-1:0]       epc,
  input logic [CAUSE_W-1:0] cause
);
  logic ovf_ev, id_ev;
  assign ovf_ev = ex_valid & ex_ovf & !redirect;
  assign id_ev  = id_valid & (id_illegal | id_syscall | irq) & !redirect;

  // R2
  ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |-> flush_ifid && flush_idex && flush_exmem && wb_squash);

  // R3
  id_keep_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_ev && !ovf_ev) |-> flush_idex && flush_ifid && !flush_exmem && !wb_squash);

  // R4
  ovf_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> epc == $past(ex_pc));

  // R5
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> cause == 5'd12);

  // R7
  redir_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev || id_ev) |=> redirect && handler_pc == VECTOR);

  // R7
  redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R8
  redir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> $stable(epc) && $stable(cause));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && !(ex_valid && ex_ovf) && !(id_valid && (id_illegal || id_syscall || irq)))
      |-> !flush_ifid && !flush_idex && !flush_exmem && !wb_squash);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_ev && !id_ev) |=> $stable(epc) && $stable(cause));
endmodule

bind exc_ctrl exc_ctrl_chk #(.W(W), .VECTOR(VECTOR)) u_chk (.*);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0;
  logic rst_n;
  logic ex_valid, ex_ovf, id_valid, id_illegal, id_syscall, irq;
  logic [31:0] ex_pc, id_pc;
  logic flush_ifid, flush_idex, flush_exmem, wb_squash, redirect;
  logic [31:0] handler_pc, epc;
  logic [4:0]  cause;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit          m_red;
  logic [31:0] m_epc;
  int          m_cause;

  always #2 clk = ~clk;

  exc_ctrl dut (.*);

  function automatic int winner();
    // returns -1 none, else cause code of the oldest event
    if (m_red) return -1;
    if (ex_valid && ex_ovf) return 12;
    if (id_valid && id_illegal) return 10;
    if (id_valid && id_syscall) return 8;
    if (id_valid && irq) return 0;
    return -1;
  endfunction

  always @(posedge clk) begin
    int w;
    w = winner();
    if (!rst_n) begin
      m_red = 0; m_epc = 0; m_cause = 0;
    end else if (m_red) begin
      m_red = 0;
    end else if (w >= 0) begin
      m_red   = 1;
      m_cause = w;
      m_epc   = (w == 12) ? ex_pc : id_pc;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int w;
    bit t, ex;
    w  = winner();
    t  = (w >= 0);
    ex = (w == 12);
    cmp("flush_ifid",  {31'd0, flush_ifid},  {31'd0, t | m_red});
    cmp("flush_idex",  {31'd0, flush_idex},  {31'd0, t});
    cmp("flush_exmem", {31'd0, flush_exmem}, {31'd0, ex});
    cmp("wb_squash",   {31'd0, wb_squash},   {31'd0, ex});
    cmp("redirect",    {31'd0, redirect},    {31'd0, m_red});
    cmp("handler_pc",  handler_pc,           m_red ? VEC : 32'd0);
    cmp("epc",         epc,                  m_epc);
    cmp("cause",       {27'd0, cause},       m_cause[31:0]);
  endtask

  task automatic step(string tag, bit exv, bit ov, logic [31:0] xpc,
                      bit idv, bit il, bit sc, bit iq, logic [31:0] ipc);
    @(negedge clk);
    cur_req = tag;
    ex_valid = exv; ex_ovf = ov; ex_pc = xpc;
    id_valid = idv; id_illegal = il; id_syscall = sc; irq = iq; id_pc = ipc;
    #1 compare_all();
  endtask

  task automatic idle(string tag);
    step(tag, 1, 0, 32'h40, 1, 0, 0, 0, 32'h44);
  endtask

  initial begin
    rst_n = 0;
    ex_valid = 0; ex_ovf = 0; ex_pc = 0;
    id_valid = 0; id_illegal = 0; id_syscall = 0; irq = 0; id_pc = 0;
    m_red = 0; m_epc = 0; m_cause = 0;
    // R1 reset state
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk) rst_n = 1;
    idle("R1");
    idle("R11");

    // R2 overflow, then R4/R5 captured, R7 redirect
    step("R2", 1, 1, 32'h1000_0040, 1, 0, 0, 0, 32'h1000_0044);
    idle("R7");
    idle("R4");
    idle("R11");

    // R3 invalid opcode keeps the execute instruction
    step("R3", 1, 0, 32'h2000_0010, 1, 1, 0, 0, 32'h2000_0014);
    idle("R7");
    idle("R5");
    // R5 syscall code
    step("R5", 1, 0, 32'h2000_0100, 1, 0, 1, 0, 32'h2000_0104);
    idle("R7");
    idle("R5");

    // R6 priority mixes
    step("R6", 1, 1, 32'h3000_0000, 1, 1, 1, 1, 32'h3000_0004);
    idle("R6");
    idle("R6");
    step("R6", 1, 0, 32'h3000_0020, 1, 1, 1, 1, 32'h3000_0024);
    idle("R6");
    step("R6", 1, 0, 32'h3000_0040, 1, 0, 1, 1, 32'h3000_0044);
    idle("R6");

    // R8 events during the redirect cycle are ignored
    step("R8", 1, 1, 32'h4000_0000, 1, 0, 0, 0, 32'h4000_0004);
    step("R8", 1, 1, 32'h4000_0100, 1, 1, 1, 1, 32'h4000_0104);
    idle("R8");

    // R9 gated by stage valid
    step("R9", 0, 1, 32'h5000_0000, 0, 1, 1, 1, 32'h5000_0004);
    idle("R9");
    step("R9", 1, 0, 32'h5000_0010, 0, 1, 0, 0, 32'h5000_0014);
    idle("R9");

    // R10 interrupt waits for a valid decode slot
    step("R10", 1, 0, 32'h6000_0000, 0, 0, 0, 1, 32'h6000_0004);
    step("R10", 1, 0, 32'h6000_0008, 1, 0, 0, 1, 32'h6000_000c);
    step("R10", 1, 0, 32'h6000_0010, 1, 0, 0, 0, 32'h6000_0014);
    idle("R10");

    // back-to-back events right after a redirect
    step("R7", 1, 0, 32'h7000_0000, 1, 1, 0, 0, 32'h7000_0004);
    idle("R7");
    step("R7", 1, 1, 32'h7000_0100, 1, 0, 0, 0, 32'h7000_0104);
    idle("R7");
    idle("R11");

    // random mixes
    for (int i = 0; i < 400; i++) begin
      step("R6", $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, $urandom,
           $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 4) == 0, $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule